// File: doc/BRIEF.md
# Chroma 4:2:2 to 4:4:4 Upsampler

This block turns a video stream whose chroma is subsampled horizontally by two into a stream that carries a full set of Y, Cb and Cr on every pixel, with 12-bit components throughout. Each input pixel brings one luma sample and one chroma sample. Even positions in a line carry Cb and odd positions carry Cr, and a line always opens on an even position. The block keeps the chroma that arrived with a pixel. It fills in the component that pixel lacks from the neighbouring pixels, which carry that component at their own sites.

A one-bit mode input chooses how the gap is filled. In hold mode the pixel takes the sample of the previous pixel. In blend mode it takes the rounded mean of the previous and following pixels. Where a neighbour is missing at a line edge, the block uses whichever neighbour exists. Luma is carried through untouched. Every output appears exactly two clock cycles after its input, and the output valid strobe follows the same delay.

A line is a run of consecutive valid cycles that starts with the line-start strobe. The line ends when valid drops, or when the next valid cycle raises line-start again. The mode value applied to a pixel is the one present in the cycle in which that pixel is presented.

Top module: `chroma_up422`

## Requirements
- R1: `out_y` equals the `in_y` that was presented exactly two clock cycles earlier, whenever `out_valid` is high.
- R2: `out_valid` equals `in_valid` delayed by exactly two clock cycles.
- R3: Within a line, the position counts from 0 at the line-start pixel. On even positions `out_cb` equals the pixel's own `in_c`, and on odd positions `out_cr` equals the pixel's own `in_c`.
- R4: With `mode_interp`=0, a pixel that has both neighbours in its line gets its missing component equal to the previous pixel's `in_c`.
- R5: With `mode_interp`=1, a pixel that has both neighbours gets its missing component equal to (prev + next + 1) >> 1, computed without overflow, so 4095 and 4095 give 4095.
- R6: A pixel with no previous pixel in its line but with a next one takes the next pixel's `in_c` as its missing component, in both modes.
- R7: A pixel with a previous pixel but no next one in its line takes the previous pixel's `in_c`, in both modes. A line's last pixel is followed by a cycle with `in_valid` low or `in_sol` high.
- R8: A one-pixel line produces the midpoint value 2048 for its missing component.
- R9: The fill mode used for a pixel is the `mode_interp` value sampled in that pixel's input cycle, even when the mode changes from pixel to pixel.
- R10: While `out_valid` is low, `out_y`, `out_cb` and `out_cr` are all zero.
- R11: During reset `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_sol | input | 1 | Marks the first pixel of a line |
| in_y | input | 12 | Input luma |
| in_c | input | 12 | Input chroma (Cb on even positions, Cr on odd positions) |
| mode_interp | input | 1 | 0 = hold previous sample, 1 = rounded mean of neighbours |
| out_valid | output | 1 | Output pixel present |
| out_y | output | 12 | Output luma |
| out_cb | output | 12 | Output Cb |
| out_cr | output | 12 | Output Cr |

## Verification
The bench targets line edges: one-pixel lines, lines of odd length, and lines that follow the previous one with no idle cycle. A design that took its neighbour across a line boundary would leak chroma from the adjacent line into these edge pixels. All-maximum chroma exposes a blend that drops its carry and wraps to a small value. An alternating pattern, whose neighbour sums are odd, catches a mean that truncates instead of rounding up. Lines whose mode flips on every pixel catch a design that samples the mode one cycle late and applies the wrong fill to the pixel.

// File: rtl/chroma_up_pkg.sv
package chroma_up_pkg;
    typedef enum logic [1:0] {
        SRC_BLEND = 2'd0,
        SRC_PREV  = 2'd1,
        SRC_NEXT  = 2'd2,
        SRC_MID   = 2'd3
    } fill_src_e;
endpackage

// File: rtl/chroma_up_avg.sv
module chroma_up_avg #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] a,
    input  logic [CW-1:0] b,
    output logic [CW-1:0] mean
);
    localparam int SW = CW + 1;
    logic [SW-1:0] sum;
    // one extra bit keeps the carry; adding one rounds half up
    assign sum  = {1'b0, a} + {1'b0, b} + SW'(1);
    assign mean = sum[SW-1:1];
endmodule

// File: rtl/chroma_up_fill.sv
module chroma_up_fill
    import chroma_up_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic [CW-1:0] prev_c,
    input  logic [CW-1:0] next_c,
    input  logic          has_prev,
    input  logic          has_next,
    input  logic          interp,
    output logic [CW-1:0] fill_c
);
    localparam logic [CW-1:0] MIDPOINT = CW'(1) << (CW - 1);

    logic [CW-1:0] blend;
    fill_src_e     src;

    chroma_up_avg #(.CW(CW)) u_avg (
        .a    (prev_c),
        .b    (next_c),
        .mean (blend)
    );

    always_comb begin
        if (has_prev && has_next) src = interp ? SRC_BLEND : SRC_PREV;
        else if (has_prev)        src = SRC_PREV;
        else if (has_next)        src = SRC_NEXT;
        else                      src = SRC_MID;
    end

    always_comb begin
        unique case (src)
            SRC_BLEND: fill_c = blend;
            SRC_PREV:  fill_c = prev_c;
            SRC_NEXT:  fill_c = next_c;
            default:   fill_c = MIDPOINT;
        endcase
    end
endmodule

// File: rtl/chroma_up422.sv
module chroma_up422 #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic [CW-1:0] in_y,
    input  logic [CW-1:0] in_c,
    input  logic          mode_interp,
    output logic          out_valid,
    output logic [CW-1:0] out_y,
    output logic [CW-1:0] out_cb,
    output logic [CW-1:0] out_cr
);
    // first stage: pixel waiting one cycle for its right-hand neighbour
    typedef struct packed {
        logic          vld;
        logic          odd;
        logic          has_prev;
        logic          interp;
        logic [CW-1:0] y;
        logic [CW-1:0] c;
        logic [CW-1:0] prev_c;
    } hold_t;

    typedef struct packed {
        logic          vld;
        logic [CW-1:0] y;
        logic [CW-1:0] cb;
        logic [CW-1:0] cr;
    } pix_t;

    typedef struct packed {
        hold_t s1;
        pix_t  o;
        logic  par;   // parity of the next pixel in the line
    } state_t;

    state_t        st_d, st_q;
    logic          has_next;
    logic [CW-1:0] fill_c;

    assign has_next = in_valid && !in_sol && st_q.s1.vld;

    chroma_up_fill #(.CW(CW)) u_fill (
        .prev_c   (st_q.s1.prev_c),
        .next_c   (in_c),
        .has_prev (st_q.s1.has_prev),
        .has_next (has_next),
        .interp   (st_q.s1.interp),
        .fill_c   (fill_c)
    );

    always_comb begin
        st_d = st_q;

        st_d.s1.vld      = in_valid;
        st_d.s1.odd      = in_sol ? 1'b0 : st_q.par;
        st_d.s1.has_prev = in_valid && !in_sol && st_q.s1.vld;
        st_d.s1.interp   = mode_interp;
        st_d.s1.y        = in_y;
        st_d.s1.c        = in_c;
        st_d.s1.prev_c   = st_q.s1.c;

        if (in_valid) begin
            st_d.par = in_sol ? 1'b1 : ~st_q.par;
        end

        st_d.o = '0;
        if (st_q.s1.vld) begin
            st_d.o.vld = 1'b1;
            st_d.o.y   = st_q.s1.y;
            st_d.o.cb  = st_q.s1.odd ? fill_c : st_q.s1.c;
            st_d.o.cr  = st_q.s1.odd ? st_q.s1.c : fill_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o.vld;
    assign out_y     = st_q.o.y;
    assign out_cb    = st_q.o.cb;
    assign out_cr    = st_q.o.cr;
endmodule

// File: rtl/chroma_up422_chk.sv
module chroma_up422_chk #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_sol,
    input logic [CW-1:0] in_y,
    input logic [CW-1:0] in_c,
    input logic          out_valid,
    input logic [CW-1:0] out_y,
    input logic [CW-1:0] out_cb
);
    logic          v1, v2, s1, s2;
    logic [CW-1:0] y1, y2, c1, c2;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0; v2 <= 1'b0; s1 <= 1'b0; s2 <= 1'b0;
            y1 <= '0;   y2 <= '0;   c1 <= '0;   c2 <= '0;
        end else begin
            v1 <= in_valid;           v2 <= v1;
            s1 <= in_valid && in_sol; s2 <= s1;
            y1 <= in_y;               y2 <= y1;
            c1 <= in_c;               c2 <= c1;
        end
    end

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2);

    // R1
    luma_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_y == y2);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_y == '0 && out_cb == '0));

    // R3
    line_head_cb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && s2) |-> out_cb == c2);
endmodule

bind chroma_up422 chroma_up422_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sol    (in_sol),
    .in_y      (in_y),
    .in_c      (in_c),
    .out_valid (out_valid),
    .out_y     (out_y),
    .out_cb    (out_cb)
);

// File: tb/chroma_up422_bench.sv
module chroma_up422_bench;
    localparam int CLK_P = 10;
    localparam int CW    = 12;
    localparam int DEPTH = 4096;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_sol = 1'b0;
    logic [CW-1:0] in_y = '0;
    logic [CW-1:0] in_c = '0;
    logic          mode_interp = 1'b0;
    logic          out_valid;
    logic [CW-1:0] out_y, out_cb, out_cr;

    bit          t_v [DEPTH];
    bit          t_s [DEPTH];
    bit          t_m [DEPTH];
    int          t_y [DEPTH];
    int          t_c [DEPTH];
    int          t_p [DEPTH];
    int          gi = 0;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_P/2) clk = ~clk;

    chroma_up422 #(.CW(CW)) u_chroma_up422 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol),
        .in_y(in_y), .in_c(in_c), .mode_interp(mode_interp),
        .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    task automatic chk(input bit ok, input string tag, input int k,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: pixel cycle %0d got %0d expected %0d", tag, k, act, exp);
        end
    endtask

    task automatic put(input bit v, input bit s, input int y, input int c,
                       input bit m, input int p);
        if (gi < DEPTH - 4) begin
            t_v[gi] = v; t_s[gi] = s; t_y[gi] = y; t_c[gi] = c;
            t_m[gi] = m; t_p[gi] = p;
            gi++;
        end
    endtask

    // msel: 0 hold, 1 blend, 2 random per pixel; cpat: 0 random, 1 all max, 2 rounding ramp
    task automatic line(input int len, input int gap, input int msel, input int cpat);
        for (int i = 0; i < len; i++) begin
            int  c;
            bit  m;
            case (cpat)
                1:       c = 4095;
                2:       c = (i / 2) % 2;
                default: c = $urandom % 4096;
            endcase
            m = (msel == 2) ? 1'($urandom % 2) : 1'(msel);
            put(1'b1, i == 0, $urandom % 4096, c, m, i);
        end
        for (int i = 0; i < gap; i++) put(1'b0, 1'b0, 0, 0, 1'b0, 0);
    endtask

    function automatic int rnd_mean(input int a, input int b);
        return (a + b + 1) / 2;
    endfunction

    task automatic check_pixel(input int k);
        chk(out_valid == t_v[k], "R2", k, out_valid, t_v[k]);
        if (!t_v[k]) begin
            chk(out_y == 0 && out_cb == 0 && out_cr == 0, "R10", k,
                out_y | out_cb | out_cr, 0);
        end else begin
            bit    odd, hp, hn;
            int    mexp, mact, own;
            string tag;
            odd = t_p[k][0];
            hp  = (k > 0) && t_v[k-1] && !t_s[k];
            hn  = t_v[k+1] && !t_s[k+1];
            chk(out_y == t_y[k], "R1", k, out_y, t_y[k]);
            own  = odd ? int'(out_cr) : int'(out_cb);
            mact = odd ? int'(out_cb) : int'(out_cr);
            chk(own == t_c[k], "R3", k, own, t_c[k]);
            if (hp && hn) begin
                mexp = t_m[k] ? rnd_mean(t_c[k-1], t_c[k+1]) : t_c[k-1];
                tag  = t_m[k] ? "R5" : "R4";
                if (t_m[k] != t_m[k-1]) chk(mact == mexp, "R9", k, mact, mexp);
            end else if (hp) begin
                mexp = t_c[k-1]; tag = "R7";
            end else if (hn) begin
                mexp = t_c[k+1]; tag = "R6";
            end else begin
                mexp = 2048; tag = "R8";
            end
            chk(mact == mexp, tag, k, mact, mexp);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL R2: watchdog expired, outputs stopped");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // directed corners
        line(1, 2, 0, 0);   // lone pixel, hold
        line(1, 1, 1, 0);   // lone pixel, blend
        line(6, 0, 1, 1);   // all max, back to back
        line(9, 0, 1, 2);   // rounding ramp, odd length
        line(7, 3, 0, 0);   // odd length, hold
        line(10, 0, 2, 0);  // mode flips per pixel
        line(2, 1, 1, 0);
        line(1, 0, 1, 0);   // lone pixel directly followed by a line
        line(8, 2, 2, 2);
        for (int n = 0; n < 40; n++)
            line(1 + $urandom % 40, $urandom % 4, $urandom % 3, $urandom % 3);
        for (int n = 0; n < 3; n++) put(1'b0, 1'b0, 0, 0, 1'b0, 0);

        // reset phase
        repeat (3) begin
            @(negedge clk);
            chk(out_valid == 1'b0, "R11", -1, out_valid, 0);
        end
        rst_n = 1'b1;
        for (int j = 0; j < gi + 2; j++) begin
            if (j >= 2) check_pixel(j - 2);
            in_valid    = t_v[j];
            in_sol      = t_s[j];
            in_y        = CW'(t_y[j]);
            in_c        = CW'(t_c[j]);
            mode_interp = t_m[j];
            @(negedge clk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule